// File: doc/BRIEF.md
# Row-Wise Event-Driven Spiking Convolution Engine

This block takes one address event at a time, made of a pixel column, a pixel row and a polarity bit. For each event it adds a small convolution kernel, centred on the event pixel, into a square map of leaky integrate-and-fire neurons. The neuron state is held in an internal register array. Each neuron has a signed membrane potential, a leak timestamp, a refractory timestamp and a flag that records whether it has ever fired. The engine works through the kernel one row per cycle. In that cycle every neuron of the window row is read, updated by its own neuron update unit and written back. The neurons of that row that fire are then sent out one by one on a ready/valid output port.

Two kernels are stored, one for each input polarity, and the latched polarity picks which one is used. The kernel edge length, the firing threshold, the leak period and the refractory period come in on configuration inputs. A timestamp input provides the current time. Configuration and the timestamp are sampled when an event is accepted and must stay stable while the engine is busy. The map is 2^ADDR_W neurons on each side, and neuron (x, y) sits at linear index y*2^ADDR_W + x.

Top module: `scnn_row_conv_engine`

## Requirements
- R1: After reset, busy and out_valid are low, in_ready is high, every potential is zero and no neuron is refractory. With threshold 1 and a coefficient of 1, a first event therefore fires its neuron.
- R2: An event is taken on a cycle where in_valid and in_ready are both high. in_ready is high only while the engine is idle. busy is high from the cycle after acceptance until the last output event has been handed over. in_valid while busy is ignored.
- R3: The kernel edge k is cfg_ksize, from 1 to 7. Kernel row r and column c, each 0 to k-1, act on the neuron at (x + c - (k-1)/2, y + r - (k-1)/2), using integer division.
- R4: Coefficient (pol, r, c) is a signed KW-bit value at bit offset ((pol*KMAX + r)*KMAX + c)*KW of cfg_kernels. pol is 1 for an ON event and 0 for an OFF event.
- R5: When a neuron that is not refractory is updated and (now - leak timestamp) modulo 2^TS_W is at least cfg_leak_time, its potential is first shifted right arithmetically by one and the leak timestamp becomes now.
- R6: A neuron that has fired before and for which (now - refractory timestamp) modulo 2^TS_W is less than cfg_refr_time is left completely unchanged by the event.
- R7: After the coefficient is added, a neuron whose potential is at least cfg_threshold fires. It sends one output event carrying its own address, its potential becomes 0 and its refractory timestamp becomes now.
- R8: The sum of potential and coefficient saturates to the signed POT_W-bit range and never wraps.
- R9: Window positions outside the map are skipped. No state is read or written for them and no output event is produced for them. Neurons outside the window keep their state.
- R10: Output events come out in ascending kernel row, and in ascending column within a row.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_x and out_y hold their values.
- R12: With out_ready held high, busy lasts exactly k cycles plus one cycle for each output event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ksize | input | KSZ_W | Kernel edge length, 1 to KMAX |
| cfg_kernels | input | 2*KMAX*KMAX*KW | Packed coefficients for both polarities |
| cfg_threshold | input | POT_W | Signed firing threshold |
| cfg_leak_time | input | TS_W | Minimum time between leak steps |
| cfg_refr_time | input | TS_W | Refractory period after a spike |
| time_now | input | TS_W | Current timestamp |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Engine idle, event can be taken |
| in_x | input | ADDR_W | Event column |
| in_y | input | ADDR_W | Event row |
| in_pol | input | 1 | Event polarity, 1 for ON |
| busy | output | 1 | Event in progress |
| out_valid | output | 1 | Output spike present |
| out_ready | input | 1 | Downstream can take the spike |
| out_x | output | ADDR_W | Spike column |
| out_y | output | ADDR_W | Spike row |

## Verification
A corrupted potential, timestamp or fired flag stays hidden until some later event touches that neuron again. It then shows up as a spike that is missing, extra or at the wrong time. For this reason the bench keeps a full shadow map and compares the complete spike sequence of every event, so that such damage is caught within one or two events on the same pixels. Mistakes in window geometry or kernel indexing show up at once as spikes at the wrong addresses or in the wrong order. An off-by-one in the row sequencing shows up at once as a wrong busy length.

// File: rtl/scnn_pkg.sv
// Shared definitions for the row-wise spiking convolution engine.
// Assumes: nothing beyond the standard language.
package scnn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_EMIT
    } eng_state_e;
endpackage

// File: rtl/scnn_neuron_update.sv
// Combinational update of one leaky integrate-and-fire neuron hit by one
// kernel coefficient: refractory gate, leak halving, saturating add, firing.
// Assumes: timestamps wrap modulo 2^TS_W; thr_i is a positive threshold.
module scnn_neuron_update #(
    parameter int POT_W = 12,
    parameter int TS_W  = 12,
    parameter int KW    = 4
) (
    input  logic signed [POT_W-1:0] pot_i,
    input  logic        [TS_W-1:0]  refts_i,
    input  logic        [TS_W-1:0]  leakts_i,
    input  logic                    armed_i,
    input  logic signed [KW-1:0]    coef_i,
    input  logic        [TS_W-1:0]  now_i,
    input  logic signed [POT_W-1:0] thr_i,
    input  logic        [TS_W-1:0]  leak_time_i,
    input  logic        [TS_W-1:0]  refr_time_i,
    output logic signed [POT_W-1:0] pot_o,
    output logic        [TS_W-1:0]  refts_o,
    output logic        [TS_W-1:0]  leakts_o,
    output logic                    armed_o,
    output logic                    fire_o
);
    localparam logic signed [POT_W:0] SUM_MAX = {2'b00, {(POT_W-1){1'b1}}};
    localparam logic signed [POT_W:0] SUM_MIN = {2'b11, {(POT_W-1){1'b0}}};

    logic        [TS_W-1:0]  age_refr;
    logic        [TS_W-1:0]  age_leak;
    logic                    in_refr;
    logic                    leak_due;
    logic signed [POT_W-1:0] base;
    logic signed [POT_W:0]   sum;
    logic signed [POT_W-1:0] sat;

    // Compute the neuron's next state from its current state and coefficient.
    always_comb begin
        age_refr = now_i - refts_i;
        age_leak = now_i - leakts_i;
        in_refr  = armed_i && (age_refr < refr_time_i);
        leak_due = (age_leak >= leak_time_i);
        base     = leak_due ? (pot_i >>> 1) : pot_i;
        sum      = {base[POT_W-1], base} + {{(POT_W+1-KW){coef_i[KW-1]}}, coef_i};
        if (sum > SUM_MAX)      sat = SUM_MAX[POT_W-1:0];
        else if (sum < SUM_MIN) sat = SUM_MIN[POT_W-1:0];
        else                    sat = sum[POT_W-1:0];
        if (in_refr) begin
            pot_o    = pot_i;
            refts_o  = refts_i;
            leakts_o = leakts_i;
            armed_o  = armed_i;
            fire_o   = 1'b0;
        end else begin
            fire_o   = (sat >= thr_i);
            pot_o    = fire_o ? '0 : sat;
            refts_o  = fire_o ? now_i : refts_i;
            leakts_o = leak_due ? now_i : leakts_i;
            armed_o  = armed_i | fire_o;
        end
    end
endmodule

// File: rtl/scnn_fire_picker.sv
// Picks the lowest set bit of a fire mask so that spikes leave in ascending
// column order.
// Assumes: N >= 2.
module scnn_fire_picker #(
    parameter int N = 7,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Scan from the top down so the lowest set bit is the one kept.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
        any_o = |mask_i;
    end
endmodule

// File: rtl/scnn_row_conv_engine.sv
// Event-driven convolution engine. It takes one (x, y, pol) event, updates
// the kernel window one row per cycle through parallel neuron update units,
// writes the states back and sends the firing neurons out one per handshake.
// Assumes: configuration and time_now are stable while an event is accepted;
// the state map is a register array of (2^ADDR_W)^2 neurons.
module scnn_row_conv_engine
    import scnn_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int KMAX   = 7,
    parameter int KW     = 4,
    parameter int POT_W  = 12,
    parameter int TS_W   = 12,
    localparam int KSZ_W = $clog2(KMAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [KSZ_W-1:0]           cfg_ksize,
    input  logic [2*KMAX*KMAX*KW-1:0]  cfg_kernels,
    input  logic signed [POT_W-1:0]    cfg_threshold,
    input  logic [TS_W-1:0]            cfg_leak_time,
    input  logic [TS_W-1:0]            cfg_refr_time,
    input  logic [TS_W-1:0]            time_now,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [ADDR_W-1:0]          in_x,
    input  logic [ADDR_W-1:0]          in_y,
    input  logic                       in_pol,
    output logic                       busy,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [ADDR_W-1:0]          out_x,
    output logic [ADDR_W-1:0]          out_y
);
    localparam int GRID   = 1 << ADDR_W;
    localparam int NCELL  = GRID * GRID;
    localparam int CELL_W = 2 * ADDR_W;
    localparam int PICK_W = $clog2(KMAX);
    localparam int BANK_W = KMAX * KMAX * KW;
    localparam int KROW_W = KMAX * KW;

    eng_state_e            state_q;
    logic [ADDR_W-1:0]     ev_x_q, ev_y_q, rowy_q;
    logic                  ev_pol_q;
    logic [KSZ_W-1:0]      ev_ks_q, row_q, off;
    logic [TS_W-1:0]       ev_time_q;
    logic [KMAX-1:0]       mask_q, fire_mask, col_ok, fire_c, mask_rest;
    logic                  last_row, row_ok;
    int                    row_s, coef_base, ox;

    logic signed [POT_W-1:0] pot_q   [NCELL];
    logic        [TS_W-1:0]  refts_q [NCELL];
    logic        [TS_W-1:0]  leakts_q[NCELL];
    logic                    armed_q [NCELL];

    logic [CELL_W-1:0]       cell_idx [KMAX];
    logic signed [KW-1:0]    coef     [KMAX];
    logic signed [POT_W-1:0] nxt_pot  [KMAX];
    logic [TS_W-1:0]         nxt_refts[KMAX];
    logic [TS_W-1:0]         nxt_leak [KMAX];
    logic                    nxt_armed[KMAX];

    logic [PICK_W-1:0]       pick_idx;
    logic                    pick_any;

    // Work out the current window row and the coefficient base of the active bank.
    always_comb begin
        off       = (ev_ks_q - KSZ_W'(1)) >> 1;
        row_s     = int'(ev_y_q) + int'(row_q) - int'(off);
        row_ok    = (row_s >= 0) && (row_s < GRID);
        last_row  = (row_q == ev_ks_q - KSZ_W'(1));
        coef_base = int'(ev_pol_q) * BANK_W + int'(row_q) * KROW_W;
    end

    for (genvar c = 0; c < KMAX; c++) begin : g_col
        int col_s;
        // Column address of this lane and whether it lies inside the map.
        always_comb begin
            col_s = int'(ev_x_q) + c - int'(off);
        end
        assign col_ok[c]   = row_ok && (KSZ_W'(c) < ev_ks_q) && (col_s >= 0) && (col_s < GRID);
        assign cell_idx[c] = {row_s[ADDR_W-1:0], col_s[ADDR_W-1:0]};
        assign coef[c]     = cfg_kernels[coef_base + c*KW +: KW];

        scnn_neuron_update #(.POT_W(POT_W), .TS_W(TS_W), .KW(KW)) i_neuron (
            .pot_i       (pot_q[cell_idx[c]]),
            .refts_i     (refts_q[cell_idx[c]]),
            .leakts_i    (leakts_q[cell_idx[c]]),
            .armed_i     (armed_q[cell_idx[c]]),
            .coef_i      (coef[c]),
            .now_i       (ev_time_q),
            .thr_i       (cfg_threshold),
            .leak_time_i (cfg_leak_time),
            .refr_time_i (cfg_refr_time),
            .pot_o       (nxt_pot[c]),
            .refts_o     (nxt_refts[c]),
            .leakts_o    (nxt_leak[c]),
            .armed_o     (nxt_armed[c]),
            .fire_o      (fire_c[c])
        );
        assign fire_mask[c] = col_ok[c] & fire_c[c];
    end

    scnn_fire_picker #(.N(KMAX)) i_picker (
        .mask_i (mask_q),
        .idx_o  (pick_idx),
        .any_o  (pick_any)
    );

    // Mask left over once the current spike is handed over; also the spike's column.
    always_comb begin
        mask_rest = mask_q & ~(KMAX'(1) << pick_idx);
        ox        = int'(ev_x_q) + int'(pick_idx) - int'(off);
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign out_valid = (state_q == ST_EMIT) && pick_any;
    assign out_x     = ox[ADDR_W-1:0];
    assign out_y     = rowy_q;

    // Sequence the rows: latch the event, one update cycle per row, then drain spikes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ev_x_q    <= '0;
            ev_y_q    <= '0;
            ev_pol_q  <= 1'b0;
            ev_ks_q   <= KSZ_W'(1);
            ev_time_q <= '0;
            row_q     <= '0;
            rowy_q    <= '0;
            mask_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        ev_x_q    <= in_x;
                        ev_y_q    <= in_y;
                        ev_pol_q  <= in_pol;
                        ev_time_q <= time_now;
                        ev_ks_q   <= (cfg_ksize == '0) ? KSZ_W'(1) :
                                     (cfg_ksize > KSZ_W'(KMAX)) ? KSZ_W'(KMAX) : cfg_ksize;
                        row_q     <= '0;
                        state_q   <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    mask_q <= fire_mask;
                    rowy_q <= row_s[ADDR_W-1:0];
                    if (|fire_mask)    state_q <= ST_EMIT;
                    else if (last_row) state_q <= ST_IDLE;
                    else               row_q   <= row_q + KSZ_W'(1);
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        mask_q <= mask_rest;
                        if (mask_rest == '0) begin
                            if (last_row) state_q <= ST_IDLE;
                            else begin
                                row_q   <= row_q + KSZ_W'(1);
                                state_q <= ST_ROW;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Clear the map on reset; write back the in-map lanes of the row being updated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCELL; i++) begin
                pot_q[i]    <= '0;
                refts_q[i]  <= '0;
                leakts_q[i] <= '0;
                armed_q[i]  <= 1'b0;
            end
        end else if (state_q == ST_ROW) begin
            for (int c = 0; c < KMAX; c++) begin
                if (col_ok[c]) begin
                    pot_q[cell_idx[c]]    <= nxt_pot[c];
                    refts_q[cell_idx[c]]  <= nxt_refts[c];
                    leakts_q[cell_idx[c]] <= nxt_leak[c];
                    armed_q[cell_idx[c]]  <= nxt_armed[c];
                end
            end
        end
    end
endmodule

// File: rtl/scnn_engine_checker.sv
// Port-level protocol and geometry properties of the convolution engine,
// attached to every instance with bind.
// Assumes: synchronous active-low reset.
module scnn_engine_checker #(
    parameter int ADDR_W = 4,
    parameter int KMAX   = 7,
    localparam int KSZ_W = $clog2(KMAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_x,
    input logic [ADDR_W-1:0] in_y,
    input logic [KSZ_W-1:0]  cfg_ksize,
    input logic              busy,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_x,
    input logic [ADDR_W-1:0] out_y
);
    logic [ADDR_W-1:0] cx_q, cy_q;
    logic [KSZ_W-1:0]  ck_q;
    int                dx, dy;
    logic              win_ok;

    // Keep a private copy of the accepted event for the window check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cx_q <= '0;
            cy_q <= '0;
            ck_q <= KSZ_W'(KMAX);
        end else if (in_valid && in_ready) begin
            cx_q <= in_x;
            cy_q <= in_y;
            ck_q <= (cfg_ksize == '0) ? KSZ_W'(1) : cfg_ksize;
        end
    end

    // Distance of the outgoing spike from the event pixel.
    always_comb begin
        dx     = int'(out_x) - int'(cx_q);
        dy     = int'(out_y) - int'(cy_q);
        win_ok = (dx < int'(ck_q)) && (-dx < int'(ck_q)) &&
                 (dy < int'(ck_q)) && (-dy < int'(ck_q));
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !out_valid && in_ready));
    p_busy_blocks_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);
    p_accept_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);
    p_out_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)));
    p_out_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> win_ok);
endmodule

bind scnn_row_conv_engine scnn_engine_checker #(.ADDR_W(ADDR_W), .KMAX(KMAX)) i_engine_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_x      (in_x),
    .in_y      (in_y),
    .cfg_ksize (cfg_ksize),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_x     (out_x),
    .out_y     (out_y)
);

// File: tb/test_scnn_row_conv_engine.sv
// Self-checking bench: keeps a shadow neuron map, predicts every spike
// sequence and busy length, and drives directed and seeded random events.
module test_scnn_row_conv_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int KMAX   = 7;
    localparam int KW     = 4;
    localparam int POT_W  = 12;
    localparam int TS_W   = 12;
    localparam int KSZ_W  = $clog2(KMAX + 1);
    localparam int GRID   = 1 << ADDR_W;
    localparam int TMASK  = (1 << TS_W) - 1;
    localparam int PMAX   = (1 << (POT_W - 1)) - 1;
    localparam int PMIN   = -(1 << (POT_W - 1));

    logic clk = 1'b0, rst_n = 1'b0;
    logic [KSZ_W-1:0] cfg_ksize;
    logic [2*KMAX*KMAX*KW-1:0] cfg_kernels;
    logic signed [POT_W-1:0] cfg_threshold;
    logic [TS_W-1:0] cfg_leak_time, cfg_refr_time, time_now;
    logic in_valid, in_ready, in_pol, busy, out_valid, out_ready;
    logic [ADDR_W-1:0] in_x, in_y, out_x, out_y;

    logic signed [KW-1:0] kern [2][KMAX][KMAX];

    int m_pot [GRID*GRID];
    int m_ref [GRID*GRID];
    int m_leak[GRID*GRID];
    bit m_arm [GRID*GRID];
    int exp_x[64], exp_y[64], act_x[64], act_y[64];
    int exp_n, act_n;
    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scnn_row_conv_engine #(.ADDR_W(ADDR_W), .KMAX(KMAX), .KW(KW), .POT_W(POT_W), .TS_W(TS_W))
    i_scnn_row_conv_engine (
        .clk(clk), .rst_n(rst_n), .cfg_ksize(cfg_ksize), .cfg_kernels(cfg_kernels),
        .cfg_threshold(cfg_threshold), .cfg_leak_time(cfg_leak_time),
        .cfg_refr_time(cfg_refr_time), .time_now(time_now), .in_valid(in_valid),
        .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_pol(in_pol), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y)
    );

    // Pack the bench kernel array at the R4 bit offsets.
    always_comb begin
        cfg_kernels = '0;
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < KMAX; r++)
                for (int c = 0; c < KMAX; c++)
                    cfg_kernels[((p*KMAX + r)*KMAX + c)*KW +: KW] = kern[p][r][c];
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic fill_kernel(input int p, input int v);
        for (int r = 0; r < KMAX; r++)
            for (int c = 0; c < KMAX; c++) kern[p][r][c] = KW'(v);
    endtask

    // Reference neuron step per R5..R8; returns 1 on a spike.
    function automatic bit model_neuron(input int idx, input int coefv, input int tnow);
        int p;
        if (m_arm[idx] && (((tnow - m_ref[idx]) & TMASK) < int'(cfg_refr_time))) return 1'b0;
        p = m_pot[idx];
        if (((tnow - m_leak[idx]) & TMASK) >= int'(cfg_leak_time)) begin
            p = p >>> 1;
            m_leak[idx] = tnow;
        end
        p = p + coefv;
        if (p > PMAX) p = PMAX;
        if (p < PMIN) p = PMIN;
        if (p >= int'(cfg_threshold)) begin
            m_pot[idx] = 0;
            m_ref[idx] = tnow;
            m_arm[idx] = 1'b1;
            return 1'b1;
        end
        m_pot[idx] = p;
        return 1'b0;
    endfunction

    // Reference event per R3, R9, R10: fill the expected spike list.
    task automatic model_event(input int x, input int y, input int pol);
        int k, off, yy, xx;
        k = int'(cfg_ksize);
        off = (k - 1) / 2;
        exp_n = 0;
        for (int r = 0; r < k; r++) begin
            yy = y + r - off;
            if (yy < 0 || yy >= GRID) continue;
            for (int c = 0; c < k; c++) begin
                xx = x + c - off;
                if (xx < 0 || xx >= GRID) continue;
                if (model_neuron(yy*GRID + xx, int'(kern[pol][r][c]), int'(time_now))) begin
                    exp_x[exp_n] = xx;
                    exp_y[exp_n] = yy;
                    exp_n++;
                end
            end
        end
    endtask

    // Drive one event and compare spikes. mode 0: ready high, 1: random, 2: mostly stalled.
    task automatic run_event(input int x, input int y, input int pol, input int mode,
                             input bit poke, input string tag);
        int cycles, px, py;
        bit prev_stall, mismatch;
        model_event(x, y, pol);
        @(negedge clk);
        check(in_ready == 1'b1 && busy == 1'b0, "R2", "idle before event", int'(in_ready), 1);
        in_x = ADDR_W'(x); in_y = ADDR_W'(y); in_pol = pol[0]; in_valid = 1'b1;
        @(negedge clk);
        check(busy == 1'b1 && in_ready == 1'b0, "R2", "busy after accept", int'(busy), 1);
        if (poke) begin
            in_x = ADDR_W'(x + 5); in_y = ADDR_W'(y + 3); in_pol = ~in_pol;
        end else in_valid = 1'b0;
        cycles = 0; act_n = 0; prev_stall = 1'b0; px = 0; py = 0;
        while (busy && cycles < 5000) begin
            cycles++;
            if (prev_stall)
                check(out_valid && int'(out_x) == px && int'(out_y) == py, "R11",
                      "held spike", int'(out_x), px);
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = $urandom_range(0, 1) == 1;
                default: out_ready = (cycles % 3) == 0;
            endcase
            #1;
            if (out_valid && out_ready && act_n < 64) begin
                act_x[act_n] = out_x; act_y[act_n] = out_y; act_n++;
            end
            prev_stall = out_valid && !out_ready;
            px = out_x; py = out_y;
            @(negedge clk);
            in_valid = 1'b0;
        end
        check(act_n == exp_n, tag, "spike count", act_n, exp_n);
        mismatch = 1'b0;
        for (int i = 0; i < exp_n && i < act_n; i++)
            if (act_x[i] != exp_x[i] || act_y[i] != exp_y[i]) begin
                if (!mismatch)
                    check(1'b0, tag, "spike address (R10 order) x*16+y",
                          act_x[i]*16 + act_y[i], exp_x[i]*16 + exp_y[i]);
                mismatch = 1'b1;
            end
        if (!mismatch) check(1'b1, tag, "spike addresses", 0, 0);
        if (mode == 0)
            check(cycles == int'(cfg_ksize) + exp_n, "R12", "busy cycles",
                  cycles, int'(cfg_ksize) + exp_n);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        in_valid = 1'b0; in_x = '0; in_y = '0; in_pol = 1'b0; out_ready = 1'b1;
        cfg_ksize = 3'd1; cfg_threshold = 12'sd1; cfg_leak_time = 12'd2000;
        cfg_refr_time = '0; time_now = 12'd100;
        fill_kernel(0, 0); fill_kernel(1, 1);
        for (int i = 0; i < GRID*GRID; i++) begin
            m_pot[i] = 0; m_ref[i] = 0; m_leak[i] = 0; m_arm[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !out_valid && in_ready, "R1", "reset port state", int'(busy), 0);

        // R1: zero potential, not refractory, fires at threshold 1 on first hit
        run_event(3, 3, 1, 0, 1'b0, "R1");

        // R7: three hits of 7 against threshold 20; R2: input poked while busy
        cfg_threshold = 12'sd20; fill_kernel(1, 7);
        for (int i = 0; i < 3; i++) run_event(5, 5, 1, 0, (i == 1), "R7");

        // R4: ON bank +7, OFF bank -8 on a 3x3 window
        cfg_ksize = 3'd3; fill_kernel(0, -8);
        for (int i = 0; i < 4; i++) run_event(8, 8, (i == 2) ? 0 : 1, 0, 1'b0, "R4");

        // R9/R10: corners and edges with a 7x7 window, every in-map neuron fires
        cfg_ksize = 3'd7; cfg_threshold = 12'sd5;
        run_event(0, 0, 1, 0, 1'b0, "R9");
        run_event(15, 15, 1, 0, 1'b0, "R9");
        run_event(0, 15, 1, 1, 1'b0, "R10");
        // R11: full 49-spike burst against a mostly stalled receiver
        time_now = 12'd150;
        run_event(8, 7, 1, 2, 1'b0, "R11");

        // R5: leak halving on a 1x1 window
        cfg_ksize = 3'd1; cfg_threshold = 12'sd12; cfg_leak_time = 12'd10;
        time_now = 12'd200; run_event(2, 9, 1, 0, 1'b0, "R5");
        time_now = 12'd205; run_event(2, 9, 1, 0, 1'b0, "R5");
        time_now = 12'd300; run_event(2, 9, 1, 0, 1'b0, "R5");
        time_now = 12'd320; run_event(2, 9, 1, 0, 1'b0, "R5");
        time_now = 12'd321; run_event(2, 9, 1, 0, 1'b0, "R5");

        // R6: refractory window after a spike
        cfg_threshold = 12'sd7; cfg_refr_time = 12'd50; cfg_leak_time = 12'd4000;
        time_now = 12'd400; run_event(11, 4, 1, 0, 1'b0, "R6");
        time_now = 12'd410; run_event(11, 4, 1, 0, 1'b0, "R6");
        time_now = 12'd460; run_event(11, 4, 1, 0, 1'b0, "R6");

        // R8: positive saturation reaches the top-of-range threshold
        cfg_threshold = 12'sd2047; cfg_refr_time = '0; time_now = 12'd500;
        for (int i = 0; i < 296; i++) run_event(12, 1, 1, 0, 1'b0, "R8");

        // R3: seeded random configurations, kernels and events
        for (int b = 0; b < 25; b++) begin
            cfg_ksize = KSZ_W'($urandom_range(1, KMAX));
            cfg_threshold = POT_W'($urandom_range(1, 30));
            cfg_leak_time = TS_W'($urandom_range(5, 60));
            cfg_refr_time = TS_W'($urandom_range(0, 30));
            for (int p = 0; p < 2; p++)
                for (int r = 0; r < KMAX; r++)
                    for (int c = 0; c < KMAX; c++)
                        kern[p][r][c] = KW'($urandom_range(0, 15));
            for (int e = 0; e < 12; e++) begin
                time_now = time_now + TS_W'($urandom_range(0, 20));
                run_event($urandom_range(0, GRID-1), $urandom_range(0, GRID-1),
                          $urandom_range(0, 1), $urandom_range(0, 1), 1'b0, "R3");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule